// File: doc/BRIEF.md
# Toggle-Requested Word RAM with Accumulating Sequencer

This block couples a single-port 32-bit word memory to a small rising-edge sequencer. The sequencer never indexes the storage array. For each access it registers a byte address, write data and a write strobe, then inverts a one-bit request flag. A driver process clocked on the falling edge compares that flag with its own copy of the last flag it serviced. When the two differ, it performs exactly one load or one store and updates its copy. Because the array is read and written from that one process only, synthesis can map it to a block RAM.

The sequencer runs one of two jobs, chosen when `go` is accepted. The fill job stores `seed`, `seed+1`, ... into consecutive words. The accumulate job reads consecutive words and adds them into a 32-bit sum. A store costs one cycle. A load costs two cycles, because the sequencer spends one extra state after each load before it consumes the word. Byte addresses are turned into word indices by dropping their two low bits, which divides them by four, and consecutive words wrap around the end of the memory. A byte base address that is not a multiple of four is still used, with its low bits ignored, and it raises a sticky flag.

Top module: `toggle_ram_accum`

## Requirements
- R1: While `rst` is high and after it is released, `sum`, `done`, `misaligned` and `rd_word` are 0. Memory contents are not cleared by reset.
- R2: A fill job with count N>0 writes `seed+i` (mod 2^32) to word index `(base_addr>>2)+i` mod DEPTH, for i = 0..N-1. `done` rises N rising edges after the edge that accepts `go`.
- R3: An accumulate job with count N>0 presents in `sum` the mod-2^32 sum of words `(base_addr>>2)+i` mod DEPTH, for i = 0..N-1. `done` rises 2N rising edges after the accepting edge. The extra cycle per load is a wait state, and no new request is issued in the cycle that follows a load request.
- R4: A job with count 0 of either kind makes no memory access and sets `done` on the accepting edge itself, with `sum` equal to 0.
- R5: `rd_word` holds the word returned by the most recent load. Stores and idle cycles leave it unchanged.
- R6: The two low bits of `base_addr` are ignored. If either is 1 when `go` is accepted, `misaligned` becomes 1 and stays 1 until reset.
- R7: `go` has no effect while a job is running. Neither the result, the latency nor the memory contents change.
- R8: `done` is cleared when `go` is accepted for a job with count above 0. Otherwise it stays high, and `sum` stays stable, until the next accepted `go`.
- R9: At most one memory access occurs per clock cycle. Every request is serviced on the falling edge that directly follows the rising edge that issued it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The sequencer uses rising edges and the memory driver uses falling edges |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a job. Accepted only while idle |
| fill_mode | input | 1 | 1 selects the fill job, 0 selects the accumulate job |
| base_addr | input | ADDR_W | Byte address of the first word |
| word_count | input | CNT_W | Number of words to process |
| seed | input | 32 | First value written by a fill job |
| sum | output | 32 | Accumulated result |
| done | output | 1 | Job finished. Held until the next accepted `go` |
| misaligned | output | 1 | Sticky flag for a base address with nonzero low bits |
| rd_word | output | 32 | Word returned by the most recent load |

## Verification
The bench uses the default parameters, ADDR_W=8 and CNT_W=7, which give a 64-word memory. A single fill can therefore cover every word, and an accumulate sweep can start from every word index with counts of 0, 1, 3, 64 and 100. The longer counts wrap around the memory end, and some of them pass the sum through 32-bit overflow. Since a count reaches beyond DEPTH, the wrap and overwrite ordering of a partial refill is also within reach. The expected sums and latencies (N and 2N) come from a bench-side word model.

// File: rtl/toggle_ram_accum.sv
module toggle_ram_accum #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              fill_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [31:0]       seed,
  output logic [31:0]       sum,
  output logic              done,
  output logic              misaligned,
  output logic [31:0]       rd_word
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_t;

  seq_t              state;
  logic              job_fill;
  logic [ADDR_W-1:0] walk_addr;
  logic [CNT_W-1:0]  left;
  logic [31:0]       next_val;

  logic              req_flag;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;

  logic              seen_flag;
  logic [31:0]       mem [DEPTH];
  logic [IDX_W-1:0]  req_idx;
  logic              pending;

  assign req_idx = req_addr[ADDR_W-1:2];
  assign pending = req_flag ^ seen_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      job_fill   <= 1'b0;
      walk_addr  <= '0;
      left       <= '0;
      next_val   <= '0;
      req_flag   <= 1'b0;
      req_we     <= 1'b0;
      req_addr   <= '0;
      req_wdata  <= '0;
      sum        <= '0;
      done       <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          done      <= 1'b0;
          sum       <= '0;
          job_fill  <= fill_mode;
          walk_addr <= {base_addr[ADDR_W-1:2], 2'b00};
          left      <= word_count;
          next_val  <= seed;
          if (base_addr[1:0] != 2'b00) misaligned <= 1'b1;
          if (word_count == '0) done <= 1'b1;
          else state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          req_flag  <= ~req_flag;
          req_we    <= job_fill;
          req_addr  <= walk_addr;
          req_wdata <= next_val;
          walk_addr <= walk_addr + ADDR_W'(4);
          next_val  <= next_val + 32'd1;
          left      <= left - 1'b1;
          if (!job_fill) state <= ST_WAIT;
          else if (left == CNT_W'(1)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          sum <= sum + rd_word;
          if (left == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      seen_flag <= 1'b0;
      rd_word   <= '0;
    end else if (pending) begin
      seen_flag <= req_flag;
      if (req_we) mem[req_idx] <= req_wdata;
      else        rd_word      <= mem[req_idx];
    end
  end

  AST_REQ_SERVICED: assert property (@(posedge clk) disable iff (rst)
    req_flag == seen_flag); // R9

  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (!req_we && (req_flag != $past(req_flag))) |=> $stable(req_flag)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($stable(req_flag) || req_we) |-> $stable(rd_word)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> (done && $stable(sum))); // R8

  AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
    misaligned |=> misaligned); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!done && !misaligned && sum == '0)); // R1

endmodule

// File: tb/toggle_ram_accum_tb.sv
`timescale 1ns/1ps
module toggle_ram_accum_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic        fill_mode = 1'b0;
  logic [7:0]  base_addr = '0;
  logic [6:0]  word_count = '0;
  logic [31:0] seed = '0;
  logic [31:0] sum;
  logic        done;
  logic        misaligned;
  logic [31:0] rd_word;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model [64];

  always #2.5 clk = ~clk;

  toggle_ram_accum #(.ADDR_W(8), .CNT_W(7)) u_dut (
    .clk(clk), .rst(rst), .go(go), .fill_mode(fill_mode),
    .base_addr(base_addr), .word_count(word_count), .seed(seed),
    .sum(sum), .done(done), .misaligned(misaligned), .rd_word(rd_word)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #900000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic run(input logic f, input logic [7:0] b, input logic [6:0] n,
                     input logic [31:0] s, output int lat);
    go = 1'b1; fill_mode = f; base_addr = b; word_count = n; seed = s;
    @(posedge clk); #1;
    go = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(posedge clk); #1;
      lat++;
    end
    if (lat >= 1000) check(1'b0, "timeout", lat, 0);
  endtask

  function automatic logic [31:0] exp_sum(input logic [7:0] b, input int n);
    logic [31:0] acc = '0;
    for (int i = 0; i < n; i++) acc += model[((b >> 2) + i) % 64];
    return acc;
  endfunction

  task automatic model_fill(input logic [7:0] b, input int n, input logic [31:0] s);
    for (int i = 0; i < n; i++) model[((b >> 2) + i) % 64] = s + 32'(i);
  endtask

  initial begin
    int lat;
    int cnts [5] = '{0, 1, 3, 64, 100};
    logic [31:0] hold;
    repeat (3) @(posedge clk);
    #1;
    check(sum == 0 && done == 0 && misaligned == 0 && rd_word == 0, "R1 in reset", sum, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(sum == 0 && done == 0 && misaligned == 0 && rd_word == 0, "R1 after reset", {done, misaligned}, 0);

    // R2: fill every word
    run(1'b1, 8'h00, 7'd64, 32'h1000_0000, lat);
    model_fill(8'h00, 64, 32'h1000_0000);
    check(lat == 64, "R2 fill latency", lat, 64);
    check(rd_word == 0, "R5 stores leave rd_word", rd_word, 0);

    // R3/R4: sweep start words and counts
    for (int w = 0; w < 64; w++) begin
      for (int c = 0; c < 5; c++) begin
        run(1'b0, 8'(w * 4), 7'(cnts[c]), 32'd0, lat);
        if (cnts[c] == 0) begin
          check(lat == 0 && sum == 0, "R4 zero count", lat, 0);
        end else begin
          check(sum == exp_sum(8'(w * 4), cnts[c]), "R3 sum", sum, exp_sum(8'(w * 4), cnts[c]));
          check(lat == 2 * cnts[c], "R3 latency", lat, 2 * cnts[c]);
          check(rd_word == model[(w + cnts[c] - 1) % 64], "R5 last load",
                rd_word, model[(w + cnts[c] - 1) % 64]);
        end
      end
    end

    // R2: wrapping partial refill with seed overflow, R5 held across stores
    hold = rd_word;
    run(1'b1, 8'(60 * 4), 7'd100, 32'hFFFF_FFF0, lat);
    model_fill(8'(60 * 4), 100, 32'hFFFF_FFF0);
    check(lat == 100, "R2 wrap fill latency", lat, 100);
    check(rd_word == hold, "R5 rd_word held over fill", rd_word, hold);
    run(1'b0, 8'h00, 7'd64, 32'd0, lat);
    check(sum == exp_sum(8'h00, 64), "R2 wrap fill contents", sum, exp_sum(8'h00, 64));
    check(rd_word == model[63], "R2 last word", rd_word, model[63]);

    // R4: zero-count fill writes nothing
    run(1'b1, 8'h00, 7'd0, 32'hDEAD_BEEF, lat);
    check(lat == 0, "R4 zero fill latency", lat, 0);
    run(1'b0, 8'h00, 7'd64, 32'd0, lat);
    check(sum == exp_sum(8'h00, 64), "R4 zero fill no write", sum, exp_sum(8'h00, 64));

    // R8: done and sum hold
    hold = sum;
    repeat (4) @(posedge clk);
    #1;
    check(done == 1 && sum == hold, "R8 done hold", {done, sum}, {1'b1, hold});

    // R7: go ignored while busy
    go = 1'b1; fill_mode = 1'b0; base_addr = 8'h10; word_count = 7'd10;
    @(posedge clk); #1;
    go = 1'b0;
    check(done == 0, "R8 done cleared on go", done, 0);
    lat = 0;
    repeat (3) begin @(posedge clk); #1; lat++; end
    go = 1'b1; fill_mode = 1'b1; base_addr = 8'h10; word_count = 7'd5; seed = 32'h0;
    @(posedge clk); #1; lat++;
    go = 1'b0;
    while (!done && lat < 1000) begin @(posedge clk); #1; lat++; end
    check(lat == 20, "R7 latency unchanged", lat, 20);
    check(sum == exp_sum(8'h10, 10), "R7 sum unchanged", sum, exp_sum(8'h10, 10));
    run(1'b0, 8'h10, 7'd5, 32'd0, lat);
    check(sum == exp_sum(8'h10, 5), "R7 memory unchanged", sum, exp_sum(8'h10, 5));

    // R6: misaligned base
    check(misaligned == 0, "R6 clear before", misaligned, 0);
    run(1'b0, 8'h0D, 7'd3, 32'd0, lat);
    check(sum == exp_sum(8'h0C, 3), "R6 low bits ignored", sum, exp_sum(8'h0C, 3));
    check(misaligned == 1, "R6 flag set", misaligned, 1);
    run(1'b1, 8'h22, 7'd2, 32'h55, lat);
    model_fill(8'h20, 2, 32'h55);
    run(1'b0, 8'h20, 7'd2, 32'd0, lat);
    check(sum == exp_sum(8'h20, 2), "R6 misaligned fill", sum, exp_sum(8'h20, 2));
    check(misaligned == 1, "R6 sticky", misaligned, 1);

    // R1: reset clears flags, keeps memory
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    check(misaligned == 0 && done == 0 && sum == 0 && rd_word == 0, "R1 second reset", {misaligned, done}, 0);
    run(1'b0, 8'h00, 7'd64, 32'd0, lat);
    check(sum == exp_sum(8'h00, 64), "R1 memory kept", sum, exp_sum(8'h00, 64));
    check(lat == 128, "R9 full latency", lat, 128);

    summary();
  end
endmodule